// File: doc/BRIEF.md
# Twelve-Hour Alarm Clock Controller

This block keeps two times of day in twelve-hour form: the running time of day and a stored wake-up time. Each holds an hour from 1 to 12, an afternoon flag and a minute from 00 to 59. A one-minute strobe from a timebase moves the running time forward. Two set buttons each move one field forward by a single step per press. The buttons arrive as one-cycle pulses that have already been debounced.

A select switch picks which of the two times the set buttons change, and also which time goes to the display. The display gets two BCD digit pairs and an afternoon lamp. An arm switch enables the wake-up output. That output is high while the running time equals the stored time in hour, afternoon flag and minute. All pins are plain level or pulse controls, so there is no streaming data and no back-pressure at the edge of the block.

Top module: `alarm_clock_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, both times read 12:00 with the afternoon flag clear. The display shows `disp_hour_bcd`=8'h12, `disp_min_bcd`=8'h00 and `pm_led`=0, and `buzzer`=0.
- R2: `disp_hour_bcd` holds the hour as two BCD digits from 8'h01 to 8'h12, and `disp_min_bcd` holds the minute from 8'h00 to 8'h59. `pm_led` is 1 for afternoon times and 0 for morning times.
- R3: Each `hour_btn` pulse moves the selected hour forward by one. The order is 1 through 12 AM, then 1 through 12 PM. The flag flips on the step from 11 to 12, and 12 steps to 1. Twenty-four pulses return the hour to its starting value.
- R4: Each `min_btn` pulse moves the selected minute forward by one. The step from 59 goes to 00 and leaves the hour and the flag unchanged.
- R5: Each `min_tick` pulse moves the running minute forward by one. The step from 59 to 00 also moves the running hour forward one step, with the same flag rule as R3.
- R6: With `mode_alarm`=0, the set buttons change only the running time, and the display shows the running time.
- R7: With `mode_alarm`=1, the set buttons change only the stored time, and the display shows the stored time. `min_tick` still advances the running time.
- R8: `buzzer` is 1 exactly when `alarm_en`=1 and the two times agree in hour, flag and minute. It holds for the whole matching minute. It falls in the same cycle that `alarm_en` goes low, with no clock edge in between.
- R9: A `min_tick` and a running-time `min_btn` pulse in the same cycle advance the minute by one step only.
- R10: A running-time `hour_btn` pulse that coincides with a tick carry out of minute 59 advances the hour by one step only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_tick | input | 1 | One-cycle pulse once per minute |
| hour_btn | input | 1 | One-cycle hour-set press |
| min_btn | input | 1 | One-cycle minute-set press |
| mode_alarm | input | 1 | 0 selects the running time, 1 selects the stored time |
| alarm_en | input | 1 | Arms the wake-up output |
| disp_hour_bcd | output | 8 | Displayed hour, two BCD digits |
| disp_min_bcd | output | 8 | Displayed minute, two BCD digits |
| pm_led | output | 1 | Afternoon flag of the displayed time |
| buzzer | output | 1 | Wake-up output |

## Verification
The hardest states to reach are the ones where two events collide. One is a tick carry out of minute 59 arriving in the same cycle as an hour press. Another is the step from 11:59 to 12:00, where the tick must flip the afternoon flag. The stimulus gets there by counting button presses from the known reset time until the minute sits at 59 and the hour at 11 or 12, and then drives both pulses in one cycle. Matching the wake-up output against a flag mismatch works the same way: the stored hour is walked through all twelve afternoon steps so the two times differ only in the flag.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int HOUR_W      = 4;
  localparam int MIN_W       = 6;
  localparam int HOURS_HALF  = 12;
  localparam int MINS_HOUR   = 60;
  localparam int BCD_W       = 8;

  typedef struct packed {
    logic              pm;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
  } tod_t;

  localparam tod_t TOD_RESET = '{pm: 1'b0, hour: HOUR_W'(HOURS_HALF), minute: '0};

  function automatic logic [BCD_W-1:0] to_bcd2(input logic [6:0] v);
    logic [3:0] tens;
    logic [3:0] ones;
    tens = 4'(v / 7'd10);
    ones = 4'(v % 7'd10);
    return {tens, ones};
  endfunction
endpackage

// File: rtl/acc_time_reg.sv
module acc_time_reg
  import acc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic min_step,
  input  logic hour_step,
  input  logic carry_en,
  output tod_t tod
);
  localparam logic [MIN_W-1:0]  MIN_LAST  = MIN_W'(MINS_HOUR - 1);
  localparam logic [HOUR_W-1:0] HOUR_TOP  = HOUR_W'(HOURS_HALF);
  localparam logic [HOUR_W-1:0] HOUR_FLIP = HOUR_W'(HOURS_HALF - 1);

  tod_t tod_q;
  logic min_wrap;
  logic hour_adv;

  assign min_wrap = (tod_q.minute == MIN_LAST);
  // one hour step even when a press and a tick carry collide
  assign hour_adv = hour_step | (min_step & carry_en & min_wrap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod_q <= TOD_RESET;
    end else begin
      if (min_step)
        tod_q.minute <= min_wrap ? '0 : tod_q.minute + 1'b1;
      if (hour_adv) begin
        tod_q.hour <= (tod_q.hour == HOUR_TOP) ? HOUR_W'(1) : tod_q.hour + 1'b1;
        if (tod_q.hour == HOUR_FLIP)
          tod_q.pm <= ~tod_q.pm;
      end
    end
  end

  assign tod = tod_q;

  // R2: fields stay in range
  a_r2_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_q.hour >= 1) && (tod_q.hour <= HOUR_TOP));
  a_r2_min_range: assert property (@(posedge clk) disable iff (!rst_n)
    tod_q.minute <= MIN_LAST);
  // R3: flag flips only on the 11 -> 12 step
  a_r3_pm_flip: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tod_q.pm) |-> (tod_q.hour == HOUR_TOP) && ($past(tod_q.hour) == HOUR_FLIP));
  // R4: minute wrap without carry leaves hour alone
  a_r4_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (min_step && !carry_en && !hour_step) |=> $stable(tod_q.hour));
  // R5: tick carry moves the hour
  a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (min_step && carry_en && min_wrap) |=> !$stable(tod_q.hour));
endmodule

// File: rtl/acc_display.sv
module acc_display
  import acc_pkg::*;
(
  input  tod_t             tod,
  output logic [BCD_W-1:0] hour_bcd,
  output logic [BCD_W-1:0] min_bcd,
  output logic             pm
);
  always_comb begin
    hour_bcd = to_bcd2(7'(tod.hour));
    min_bcd  = to_bcd2(7'(tod.minute));
    pm       = tod.pm;
  end
endmodule

// File: rtl/alarm_clock_ctrl.sv
module alarm_clock_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             min_tick,
  input  logic             hour_btn,
  input  logic             min_btn,
  input  logic             mode_alarm,
  input  logic             alarm_en,
  output logic [BCD_W-1:0] disp_hour_bcd,
  output logic [BCD_W-1:0] disp_min_bcd,
  output logic             pm_led,
  output logic             buzzer
);
  tod_t now_tod;
  tod_t wake_tod;
  tod_t shown;
  logic running_q;

  acc_time_reg u_now (
    .clk      (clk),
    .rst_n    (rst_n),
    .min_step (min_tick | (min_btn & ~mode_alarm)),
    .hour_step(hour_btn & ~mode_alarm),
    .carry_en (min_tick),
    .tod      (now_tod)
  );

  acc_time_reg u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .min_step (min_btn & mode_alarm),
    .hour_step(hour_btn & mode_alarm),
    .carry_en (1'b0),
    .tod      (wake_tod)
  );

  assign shown = mode_alarm ? wake_tod : now_tod;

  acc_display u_disp (
    .tod      (shown),
    .hour_bcd (disp_hour_bcd),
    .min_bcd  (disp_min_bcd),
    .pm       (pm_led)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) running_q <= 1'b0;
    else        running_q <= 1'b1;
  end

  assign buzzer = running_q & alarm_en & (now_tod == wake_tod);

  // R8: never sounds unarmed
  a_r8_armed: assert property (@(posedge clk) disable iff (!rst_n)
    buzzer |-> alarm_en);
  // R7: stored time holds while its buttons are not routed to it
  a_r7_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_alarm |=> $stable(wake_tod));
  // R6: running time only moves on tick or its own buttons
  a_r6_now_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_alarm && !min_tick) |=> $stable(now_tod));
endmodule

// File: tb/test_alarm_clock_ctrl.sv
`timescale 1ns/1ps
module test_alarm_clock_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic min_tick = 0, hour_btn = 0, min_btn = 0, mode_alarm = 0, alarm_en = 0;
  logic [7:0] disp_hour_bcd, disp_min_bcd;
  logic pm_led, buzzer;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alarm_clock_ctrl i_alarm_clock_ctrl (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .hour_btn(hour_btn),
    .min_btn(min_btn), .mode_alarm(mode_alarm), .alarm_en(alarm_en),
    .disp_hour_bcd(disp_hour_bcd), .disp_min_bcd(disp_min_bcd),
    .pm_led(pm_led), .buzzer(buzzer)
  );

  // [19] mode, [18:17] op (0 idle,1 tick,2 hour,3 minute), [16:9] hour, [8:1] minute, [0] pm
  localparam logic [19:0] VEC [10] = '{
    {1'b0, 2'd2, 8'h01, 8'h00, 1'b0},
    {1'b0, 2'd2, 8'h02, 8'h00, 1'b0},
    {1'b0, 2'd3, 8'h02, 8'h01, 1'b0},
    {1'b0, 2'd1, 8'h02, 8'h02, 1'b0},
    {1'b1, 2'd2, 8'h01, 8'h00, 1'b0},
    {1'b1, 2'd3, 8'h01, 8'h01, 1'b0},
    {1'b1, 2'd1, 8'h01, 8'h01, 1'b0},
    {1'b0, 2'd0, 8'h02, 8'h03, 1'b0},
    {1'b0, 2'd3, 8'h02, 8'h04, 1'b0},
    {1'b0, 2'd2, 8'h03, 8'h04, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] h, input logic [7:0] m, input logic p);
    n_run++;
    if (disp_hour_bcd !== h || disp_min_bcd !== m || pm_led !== p) begin
      n_fail++;
      $display("FAIL %s: got %h:%h pm=%b, expected %h:%h pm=%b",
               req, disp_hour_bcd, disp_min_bcd, pm_led, h, m, p);
    end
  endtask

  task automatic chk_bz(input string req, input logic e);
    n_run++;
    if (buzzer !== e) begin
      n_fail++;
      $display("FAIL %s: buzzer got %b, expected %b", req, buzzer, e);
    end
  endtask

  task automatic pulse(input logic t, input logic h, input logic m, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      min_tick = t; hour_btn = h; min_btn = m;
      @(negedge clk);
      min_tick = 0; hour_btn = 0; min_btn = 0;
    end
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mode_alarm = 0; alarm_en = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 in reset", 8'h12, 8'h00, 1'b0);
    chk_bz("R1 in reset", 1'b0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 after reset", 8'h12, 8'h00, 1'b0);
    chk_bz("R1 after reset", 1'b0);

    // table walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 10; v++) begin
      @(negedge clk);
      mode_alarm = VEC[v][19];
      case (VEC[v][18:17])
        2'd1: pulse(1, 0, 0, 1);
        2'd2: pulse(0, 1, 0, 1);
        2'd3: pulse(0, 0, 1, 1);
        default: pulse(0, 0, 0, 1);
      endcase
      chk($sformatf("R6/R7 vector %0d", v), VEC[v][16:9], VEC[v][8:1], VEC[v][0]);
    end

    do_reset();
    pulse(0, 1, 0, 11);
    chk("R3 eleven AM", 8'h11, 8'h00, 1'b0);
    pulse(0, 1, 0, 1);
    chk("R3 noon flips flag", 8'h12, 8'h00, 1'b1);
    pulse(0, 1, 0, 12);
    chk("R3 full 24 cycle", 8'h12, 8'h00, 1'b0);

    pulse(0, 0, 1, 59);
    chk("R2 R4 minute 59", 8'h12, 8'h59, 1'b0);
    pulse(0, 0, 1, 1);
    chk("R4 wrap no carry", 8'h12, 8'h00, 1'b0);

    pulse(0, 1, 0, 11);
    pulse(0, 0, 1, 59);
    chk("R4 setup 11:59", 8'h11, 8'h59, 1'b0);
    pulse(1, 0, 0, 1);
    chk("R5 tick carry to noon", 8'h12, 8'h00, 1'b1);

    pulse(1, 0, 1, 1);
    chk("R9 tick with press", 8'h12, 8'h01, 1'b1);

    pulse(0, 0, 1, 58);
    pulse(1, 1, 0, 1);
    chk("R10 press with carry", 8'h01, 8'h00, 1'b1);

    @(negedge clk); mode_alarm = 1; #1;
    chk("R6 stored untouched", 8'h12, 8'h00, 1'b0);
    pulse(0, 1, 0, 1);
    chk("R7 set stored hour", 8'h01, 8'h00, 1'b0);
    @(negedge clk); mode_alarm = 0; alarm_en = 1; #1;
    chk("R6 running shown", 8'h01, 8'h00, 1'b1);
    chk_bz("R8 flag mismatch", 1'b0);

    @(negedge clk); mode_alarm = 1;
    pulse(0, 1, 0, 12);
    chk("R7 stored 1 PM", 8'h01, 8'h00, 1'b1);
    chk_bz("R8 match", 1'b1);
    @(negedge clk); mode_alarm = 0;
    pulse(0, 0, 0, 5);
    chk_bz("R8 holds in minute", 1'b1);
    @(negedge clk); alarm_en = 0; #1;
    chk_bz("R8 drops at once", 1'b0);
    @(negedge clk); alarm_en = 1; #1;
    chk_bz("R8 re-armed", 1'b1);
    pulse(1, 0, 0, 1);
    chk("R5 tick to 1:01", 8'h01, 8'h01, 1'b1);
    chk_bz("R8 minute over", 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule